// File: doc/BRIEF.md
# Mode-Gated Pin Configuration Controller

This block records the chip's operating mode when reset is released. It then keeps three small configuration registers: a mode register, a port-control register and a pull-enable register. From the recorded mode and those registers it drives per-pin function-select, direction and pull-enable controls. These controls go to two 8-bit data ports (A and B) and one 8-bit control port (E). Software reads and writes the registers over a simple synchronous bus: one write strobe, an address, write data and combinational read data.

How the registers may be written depends on the mode. In single-chip modes, the pipe-status, low-strobe and read/write enables are held at zero, so port E can never carry those alternate functions. The mode field has its own rules. Special modes may rewrite it freely, which lifts protection for test. Normal modes may change it once per reset. Peripheral mode never accepts a write to it.

Write permission for the mode field comes from a lock state machine. Its states are LK_BOOT, LK_OPEN, LK_ONCE, LK_SHUT and LK_FROZEN.
- LK_BOOT is the first cycle after reset. Here the mode pins are captured and the register bus is ignored.
- LK_BOOT moves to LK_OPEN for special codes, to LK_FROZEN for the peripheral code, and to LK_ONCE for the other codes.
- LK_ONCE moves to LK_SHUT on the first accepted mode write.
- LK_OPEN, LK_SHUT and LK_FROZEN hold until the next reset.

Top module: `pincfg_ctrl`

## Requirements
- R1: The 3-bit mode pins are captured on the first rising clock edge after rst_n goes high. From then on, reading address 0 returns the mode in bits [7:5]. The mode codes are:
  - 000 special single-chip
  - 001 special narrow
  - 010 special test
  - 011 special wide
  - 100 normal single-chip
  - 101 normal narrow
  - 110 peripheral
  - 111 normal wide
- R2: After capture, the control register (address 1) takes a reset value that depends on the mode, and the pull register (address 2) reads 0x10. The control register's bits are: bit0 pipe enable, bit1 low-strobe enable, bit2 read/write enable, bit4 E-clock off. Its reset value is:
  - 0x00 for 000
  - 0x10 for 100
  - 0x04 for narrow codes
  - 0x06 for 010, 011, 111 and 110
- R3: While the mode is single-chip (000 or 100), control bits 2:0 read 0 and writes cannot set them. Port E pins 6, 5, 3 and 2 are then never alternate-function.
- R4: Port E pin 4 is an alternate-function output (pe_alt[4] = pe_dir[4] = 1) exactly when control bit 4 is 0, in every mode.
- R5: Port A is assigned to the bus (pa_alt all ones) in every mode except single-chip. Port B is assigned to the bus only in wide modes (010, 011, 111) and in peripheral mode.
- R6: Port E pins 6 and 5 follow the pipe enable, pin 3 follows the low-strobe enable and pin 2 follows the read/write enable, both as function select and as direction. Pins 3 and 2 are inputs in peripheral mode. Pull enables come from the pull register: bit0 for port A, bit1 for port B, bit4 for port E. A pull is active only on pins not assigned an alternate function.
- R7: While the captured mode is special (code bit 2 = 0), the mode field accepts any number of writes. Each accepted write changes the port functions at once.
- R8: While the captured mode is 100, 101 or 111, the first accepted mode write takes effect. Every later write is ignored until reset.
- R9: While the captured mode is peripheral (110), every write to address 0 is ignored.
- R10: A write of code 110 to the mode field is always ignored. It does not use up the single write allowed in normal modes.
- R11: Register bits with no function read 0, and address 3 reads 0x00.
- R12: A mode write that enters a single-chip mode clears control bits 2:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_pins | input | 3 | Mode strap inputs, sampled at reset release |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| pa_alt | output | 8 | Port A per-pin bus function select |
| pa_pull | output | 8 | Port A per-pin pull enable |
| pb_alt | output | 8 | Port B per-pin bus function select |
| pb_pull | output | 8 | Port B per-pin pull enable |
| pe_alt | output | 8 | Port E per-pin alternate function select |
| pe_dir | output | 8 | Port E per-pin output direction for alternate functions |
| pe_pull | output | 8 | Port E per-pin pull enable |

## Verification
The hardest situation to reach is the interaction in normal modes between a rejected peripheral-code write and the single allowed mode write. It only shows when a write of code 110 comes first, then a legal code, then another legal code that must bounce. The bench drives exactly that sequence after each of the eight reset captures. Before the first legal write it loads the control register with all enables set, so a move into single-chip mode shows the forced clearing at the ports. Every expected register and pin value comes from a bench model of the mode rules.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;

    localparam logic [2:0] MD_SSC  = 3'b000;
    localparam logic [2:0] MD_SNAR = 3'b001;
    localparam logic [2:0] MD_STST = 3'b010;
    localparam logic [2:0] MD_SWID = 3'b011;
    localparam logic [2:0] MD_NSC  = 3'b100;
    localparam logic [2:0] MD_NNAR = 3'b101;
    localparam logic [2:0] MD_PERI = 3'b110;
    localparam logic [2:0] MD_NWID = 3'b111;

    // field positions
    localparam int MODE_LSB = 5;
    localparam int CT_PIPE  = 0;
    localparam int CT_LSTB  = 1;
    localparam int CT_RDWR  = 2;
    localparam int CT_ECOFF = 4;
    localparam int PU_A     = 0;
    localparam int PU_B     = 1;
    localparam int PU_E     = 4;

    localparam logic [1:0] ADR_MODE = 2'd0;
    localparam logic [1:0] ADR_CTRL = 2'd1;
    localparam logic [1:0] ADR_PULL = 2'd2;

    localparam logic [7:0] CTRL_IMPL = 8'h17;
    localparam logic [7:0] PULL_IMPL = 8'h13;
    localparam logic [7:0] PULL_RST  = 8'h10;

    typedef enum logic [2:0] {
        LK_BOOT,
        LK_OPEN,
        LK_ONCE,
        LK_SHUT,
        LK_FROZEN
    } lock_e;

    function automatic logic md_single(input logic [2:0] m);
        return (m == MD_SSC) || (m == MD_NSC);
    endfunction

    function automatic logic md_peri(input logic [2:0] m);
        return m == MD_PERI;
    endfunction

    function automatic logic md_special(input logic [2:0] m);
        return !m[2];
    endfunction

    function automatic logic md_wide(input logic [2:0] m);
        return (m == MD_STST) || (m == MD_SWID) || (m == MD_NWID);
    endfunction

    function automatic logic [7:0] ctrl_default(input logic [2:0] m);
        logic [7:0] v;
        unique case (m)
            MD_SSC:           v = 8'h00;
            MD_NSC:           v = 8'h10;
            MD_SNAR, MD_NNAR: v = 8'h04;
            default:          v = 8'h06;
        endcase
        return v;
    endfunction

    // bits the control register may hold in a given mode
    function automatic logic [7:0] ctrl_keep(input logic [2:0] m);
        return md_single(m) ? 8'h10 : CTRL_IMPL;
    endfunction

endpackage

// File: rtl/pincfg_lock_fsm.sv
module pincfg_lock_fsm
    import pincfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] boot_mode,
    input  logic       mode_req,
    input  logic [2:0] req_code,
    output logic       capture,
    output logic       mode_accept
);

    lock_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_BOOT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LK_BOOT: begin
                if (md_peri(boot_mode))         state_nx = LK_FROZEN;
                else if (md_special(boot_mode)) state_nx = LK_OPEN;
                else                            state_nx = LK_ONCE;
            end
            LK_OPEN:   state_nx = LK_OPEN;
            LK_ONCE:   if (mode_accept) state_nx = LK_SHUT;
            LK_SHUT:   state_nx = LK_SHUT;
            LK_FROZEN: state_nx = LK_FROZEN;
            default:   state_nx = LK_BOOT;
        endcase
    end

    always_comb begin
        capture     = (state == LK_BOOT);
        mode_accept = mode_req && (req_code != MD_PERI) &&
                      ((state == LK_OPEN) || (state == LK_ONCE));
    end

    p_boot_leaves_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == LK_BOOT |=> state != LK_BOOT);

    p_shut_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == LK_SHUT |=> state == LK_SHUT && !mode_accept);

    p_frozen_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == LK_FROZEN |=> state == LK_FROZEN && !mode_accept);

endmodule

// File: rtl/pincfg_regs.sv
module pincfg_regs
    import pincfg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [2:0]        boot_mode,
    input  logic              mode_accept,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [2:0]        mode_q,
    output logic [7:0]        ctrl_q,
    output logic [7:0]        pull_q
);

    logic [2:0] wr_code;
    logic       wr_ctrl, wr_pull;

    assign wr_code = bus_wdata[MODE_LSB +: 3];
    assign wr_ctrl = bus_we && !capture && (bus_addr == ADDR_W'(ADR_CTRL));
    assign wr_pull = bus_we && !capture && (bus_addr == ADDR_W'(ADR_PULL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_SSC;
            ctrl_q <= 8'h00;
            pull_q <= PULL_RST;
        end else if (capture) begin
            mode_q <= boot_mode;
            ctrl_q <= ctrl_default(boot_mode);
            pull_q <= PULL_RST;
        end else begin
            if (mode_accept) begin
                mode_q <= wr_code;
                ctrl_q <= ctrl_q & ctrl_keep(wr_code);
            end else if (wr_ctrl) begin
                ctrl_q <= bus_wdata[7:0] & ctrl_keep(mode_q);
            end
            if (wr_pull) pull_q <= bus_wdata[7:0] & PULL_IMPL;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(ADR_MODE): bus_rdata[MODE_LSB +: 3] = mode_q;
            ADDR_W'(ADR_CTRL): bus_rdata[7:0] = ctrl_q;
            ADDR_W'(ADR_PULL): bus_rdata[7:0] = pull_q;
            default:           bus_rdata = '0;
        endcase
    end

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_accept && !capture) |=> $stable(mode_q));

    p_forced_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        md_single(mode_q) |-> (ctrl_q[2:0] == 3'b000));

    p_no_peri_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_q) && !$past(capture)) |-> (mode_q != MD_PERI));

endmodule

// File: rtl/pincfg_pinmux.sv
module pincfg_pinmux
    import pincfg_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_q,
    input  logic [7:0]        ctrl_q,
    input  logic [7:0]        pull_q,
    output logic [PORT_W-1:0] pa_alt,
    output logic [PORT_W-1:0] pa_pull,
    output logic [PORT_W-1:0] pb_alt,
    output logic [PORT_W-1:0] pb_pull,
    output logic [PORT_W-1:0] pe_alt,
    output logic [PORT_W-1:0] pe_dir,
    output logic [PORT_W-1:0] pe_pull
);

    logic a_bus, b_bus, peri;

    always_comb begin
        peri  = md_peri(mode_q);
        a_bus = !md_single(mode_q);
        b_bus = md_wide(mode_q) || peri;

        pa_alt  = {PORT_W{a_bus}};
        pb_alt  = {PORT_W{b_bus}};
        pa_pull = {PORT_W{pull_q[PU_A]}} & ~pa_alt;
        pb_pull = {PORT_W{pull_q[PU_B]}} & ~pb_alt;

        pe_alt    = '0;
        pe_alt[6] = ctrl_q[CT_PIPE];
        pe_alt[5] = ctrl_q[CT_PIPE];
        pe_alt[4] = !ctrl_q[CT_ECOFF];
        pe_alt[3] = ctrl_q[CT_LSTB];
        pe_alt[2] = ctrl_q[CT_RDWR];

        pe_dir    = '0;
        pe_dir[6] = ctrl_q[CT_PIPE];
        pe_dir[5] = ctrl_q[CT_PIPE];
        pe_dir[4] = !ctrl_q[CT_ECOFF];
        pe_dir[3] = ctrl_q[CT_LSTB] && !peri;
        pe_dir[2] = ctrl_q[CT_RDWR] && !peri;

        pe_pull = {PORT_W{pull_q[PU_E]}} & ~pe_alt;
    end

    p_sc_pe_gpio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        md_single(mode_q) |-> (pe_alt[6:5] == 2'b00 && pe_alt[3:2] == 2'b00));

    p_sc_no_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        md_single(mode_q) |-> (pa_alt == '0 && pb_alt == '0));

endmodule

// File: rtl/pincfg_ctrl.sv
module pincfg_ctrl
    import pincfg_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_pins,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PORT_W-1:0] pa_alt,
    output logic [PORT_W-1:0] pa_pull,
    output logic [PORT_W-1:0] pb_alt,
    output logic [PORT_W-1:0] pb_pull,
    output logic [PORT_W-1:0] pe_alt,
    output logic [PORT_W-1:0] pe_dir,
    output logic [PORT_W-1:0] pe_pull
);

    logic       capture, mode_accept, mode_req;
    logic [2:0] mode_q;
    logic [7:0] ctrl_q, pull_q;

    assign mode_req = bus_we && (bus_addr == ADDR_W'(ADR_MODE));

    pincfg_lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_mode   (mode_pins),
        .mode_req    (mode_req),
        .req_code    (bus_wdata[MODE_LSB +: 3]),
        .capture     (capture),
        .mode_accept (mode_accept)
    );

    pincfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .boot_mode   (mode_pins),
        .mode_accept (mode_accept),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .mode_q      (mode_q),
        .ctrl_q      (ctrl_q),
        .pull_q      (pull_q)
    );

    pincfg_pinmux #(.PORT_W(PORT_W)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_q  (mode_q),
        .ctrl_q  (ctrl_q),
        .pull_q  (pull_q),
        .pa_alt  (pa_alt),
        .pa_pull (pa_pull),
        .pb_alt  (pb_alt),
        .pb_pull (pb_pull),
        .pe_alt  (pe_alt),
        .pe_dir  (pe_dir),
        .pe_pull (pe_pull)
    );

endmodule

// File: tb/pincfg_ctrl_bench.sv
`timescale 1ns/1ps
module pincfg_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_pins = 3'b000;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    wire  [7:0] bus_rdata, pa_alt, pa_pull, pb_alt, pb_pull, pe_alt, pe_dir, pe_pull;

    always #4 clk = ~clk;

    pincfg_ctrl u_pincfg_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pa_alt(pa_alt), .pa_pull(pa_pull), .pb_alt(pb_alt), .pb_pull(pb_pull),
        .pe_alt(pe_alt), .pe_dir(pe_dir), .pe_pull(pe_pull)
    );

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [2:0] m_boot, m_mode;
    logic [7:0] m_ctl, m_pul;
    bit         m_used;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic bit e_sc(logic [2:0] m);   return m == 3'd0 || m == 3'd4; endfunction
    function automatic bit e_peri(logic [2:0] m); return m == 3'd6; endfunction
    function automatic bit e_wide(logic [2:0] m); return m == 3'd2 || m == 3'd3 || m == 3'd7; endfunction

    function automatic logic [7:0] e_ctl_def(logic [2:0] m);
        if (m == 3'd0) return 8'h00;
        if (m == 3'd4) return 8'h10;
        if (m == 3'd1 || m == 3'd5) return 8'h04;
        return 8'h06;
    endfunction

    function automatic logic [7:0] e_keep(logic [2:0] m);
        return e_sc(m) ? 8'h10 : 8'h17;
    endfunction

    task automatic rd(string req, logic [1:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_pins(string req);
        logic [7:0] ea, eb, eal, edr;
        ea = e_sc(m_mode) ? 8'h00 : 8'hFF;
        eb = (e_wide(m_mode) || e_peri(m_mode)) ? 8'hFF : 8'h00;
        eal = {1'b0, m_ctl[0], m_ctl[0], !m_ctl[4], m_ctl[1], m_ctl[2], 2'b00};
        edr = {1'b0, m_ctl[0], m_ctl[0], !m_ctl[4],
               m_ctl[1] && !e_peri(m_mode), m_ctl[2] && !e_peri(m_mode), 2'b00};
        check({req, " pa_alt"},  pa_alt, ea);
        check({req, " pb_alt"},  pb_alt, eb);
        check({req, " pa_pull"}, pa_pull, {8{m_pul[0]}} & ~ea);
        check({req, " pb_pull"}, pb_pull, {8{m_pul[1]}} & ~eb);
        check({req, " pe_alt"},  pe_alt, eal);
        check({req, " pe_dir"},  pe_dir, edr);
        check({req, " pe_pull"}, pe_pull, {8{m_pul[4]}} & ~eal);
    endtask

    task automatic do_reset(logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0; mode_pins = m; bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        m_boot = m; m_mode = m; m_ctl = e_ctl_def(m); m_pul = 8'h10; m_used = 0;
    endtask

    task automatic mode_write(logic [2:0] code, logic [4:0] junk, string req);
        bit acc;
        wr(2'd0, {code, junk});
        acc = !e_peri(code) &&
              (!m_boot[2] || (!e_peri(m_boot) && !m_used));
        if (acc) begin
            m_mode = code;
            m_ctl  = m_ctl & e_keep(code);
            if (m_boot[2]) m_used = 1;
        end
        rd({req, " mode read"}, 2'd0, {m_mode, 5'b0});
        rd({req, " R12 ctrl after mode write"}, 2'd1, m_ctl);
        check_pins({req, " pins"});
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int mi = 0; mi < 8; mi++) begin
            logic [2:0] m, t1;
            m = 3'(mi);
            do_reset(m);
            // R1 R2 reset state
            rd("R1 mode capture", 2'd0, {m, 5'b0});
            rd("R2 ctrl default", 2'd1, e_ctl_def(m));
            rd("R2 pull default", 2'd2, 8'h10);
            check_pins("R2 R5 R6 reset pins");
            // R3 forced bits, R11 unused bits
            wr(2'd1, 8'hFF);
            m_ctl = 8'hFF & e_keep(m_mode);
            rd("R3 R11 ctrl all-ones write", 2'd1, m_ctl);
            check_pins("R3 R4 pins after ctrl FF");
            // R4 E clock on, then off
            wr(2'd1, 8'h00);
            m_ctl = 8'h00;
            check("R4 eclk on alt", {7'b0, pe_alt[4]}, 8'h01);
            check("R4 eclk on dir", {7'b0, pe_dir[4]}, 8'h01);
            wr(2'd1, 8'h10);
            m_ctl = 8'h10;
            check("R4 eclk off alt", {7'b0, pe_alt[4]}, 8'h00);
            // R6 pulls
            wr(2'd2, 8'hFF);
            m_pul = 8'h13;
            rd("R6 R11 pull write", 2'd2, 8'h13);
            check_pins("R6 pins with pulls");
            rd("R11 addr3", 2'd3, 8'h00);
            // load all enables to observe R12
            wr(2'd1, 8'h07);
            m_ctl = 8'h07 & e_keep(m_mode);
            // R9 R10: peripheral code always rejected
            mode_write(3'd6, 5'h1F, "R9 R10 peripheral code");
            // R7 R8 R9 first legal write, R12
            t1 = (m == 3'd0) ? 3'd7 : 3'd0;
            mode_write(t1, 5'h1F, "R7 R8 R9 R11 R12 first write");
            // R7 R8 R9 second write
            mode_write(3'd5, 5'h00, "R7 R8 R9 second write");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule